// File: doc/BRIEF.md
# Dual-UART RS-232 Routing Controller

This block sits between two on-chip UARTs and a single RS-232 line driver that also carries modem-control lines. A single 8-bit register, written and read over a simple strobe bus, decides which UART owns the main transmit, receive and clear-to-send lines. When both UARTs are enabled, the second one transmits on the DTR pin and receives from the DSR pin, so the connector carries two serial channels at once.

The same register drives the RTS and DTR outputs directly and controls the force-on and force-off inputs of the line driver. All connector and UART-side outputs are combinational functions of the stored register value and the live pin inputs. A write therefore shows on the pins right after the clock edge that captures it. Level translation and the UARTs themselves are outside the block.

Register bit map:
- bit 0: keep the driver on
- bit 1: shut the driver down
- bit 2: DTR level
- bit 3: RTS level
- bit 4: reserved, always zero
- bit 5: enable UART 0
- bit 6: enable UART 1
- bit 7: select UART 1 as primary when both UARTs are enabled

Top module: `rs_port_router`

## Requirements
- R1: After reset the register reads 0x20. UART 0 alone is connected: `conTxd` follows `uartTx[0]`, and `uartRx[0]` follows `conRxd`.
- R2: A write with `busWrEn` high stores `busWrData` with bit 4 cleared, starting with the next clock edge. Without `busWrEn` the register holds its value. `busRdData` shows the register while `busRdEn` is high and reads 0x00 while it is low.
- R3: Bit 1 set drives `drvForceOff` high. Bit 0 set drives `drvForceOn` high only when bit 1 is clear. The two outputs are never high together.
- R4: `conRts` equals bit 3 at all times.
- R5: `conDtr` equals bit 2 unless bits 5 and 6 are both set. In that case bit 2 has no effect on `conDtr`.
- R6: When exactly one of bits 5 and 6 is set, that UART is primary whatever bit 7 holds. Its transmit output drives `conTxd`, its receive input gets `conRxd`, and its clear-to-send input gets `conCts`.
- R7: When bits 5 and 6 are both set, bit 7 picks the primary UART (1 selects UART 1, 0 selects UART 0) and that UART gets the R6 connections. The other UART drives `conDtr` with its transmit output and gets `conDsr` on its receive input. Its clear-to-send input is 0.
- R8: A disabled UART sees a receive input of 1 and a clear-to-send input of 0, and its transmit output reaches no connector pin. With no UART enabled, `conTxd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, zero when not reading |
| uartTx | input | 2 | Transmit outputs of UART 1 and UART 0 |
| uartRx | output | 2 | Receive inputs to UART 1 and UART 0 |
| uartCts | output | 2 | Clear-to-send inputs to UART 1 and UART 0 |
| conRxd | input | 1 | Connector receive data |
| conCts | input | 1 | Connector clear to send |
| conDsr | input | 1 | Connector DSR, secondary receive |
| conTxd | output | 1 | Connector transmit data |
| conRts | output | 1 | Connector request to send |
| conDtr | output | 1 | Connector DTR, or secondary transmit |
| drvForceOn | output | 1 | Line driver keep-on control |
| drvForceOff | output | 1 | Line driver shutdown control |

## Verification
The only state is the register, so a write is due on the read port and on every routed pin in the first cycle after the clock edge that captures it. The bench drives the write at a falling edge and samples both read data and pins at the following falling edge. Pin inputs pass through to the outputs with no register in the path. After each input change the bench waits one time step and checks within the same cycle, with no clock edge in between. The sweep covers all 256 written values, each crossed with all 32 combinations of the five routed inputs.

// File: rtl/rs_router_pkg.sv
package rs_router_pkg;
  localparam int REG_W = 8;
  localparam logic [REG_W-1:0] RESET_VAL = 8'h20;
  localparam logic [REG_W-1:0] RSV_MASK  = 8'hEF;
  localparam int B_ON   = 0;
  localparam int B_OFF  = 1;
  localparam int B_DTR  = 2;
  localparam int B_RTS  = 3;
  localparam int B_EN0  = 5;
  localparam int B_EN1  = 6;
  localparam int B_PRI1 = 7;

  typedef struct packed {
    logic en0;
    logic en1;
    logic pri1;
    logic dtrBit;
    logic rtsBit;
    logic forceOn;
    logic forceOff;
  } rsCtl_t;
endpackage

// File: rtl/rs_ctl_regs.sv
module rs_ctl_regs
  import rs_router_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWrEn,
  input  logic             busRdEn,
  input  logic [REG_W-1:0] busWrData,
  output logic [REG_W-1:0] busRdData,
  output rsCtl_t           ctl
);
  logic [REG_W-1:0] regQ;

  always_ff @(posedge clk) begin
    if (!rstN)        regQ <= RESET_VAL;
    else if (busWrEn) regQ <= busWrData & RSV_MASK;
  end

  assign busRdData = busRdEn ? regQ : '0;

  always_comb begin
    ctl.en0      = regQ[B_EN0];
    ctl.en1      = regQ[B_EN1];
    ctl.pri1     = regQ[B_PRI1];
    ctl.dtrBit   = regQ[B_DTR];
    ctl.rtsBit   = regQ[B_RTS];
    ctl.forceOn  = regQ[B_ON];
    ctl.forceOff = regQ[B_OFF];
  end

  // R1
  reset_val_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> regQ == RESET_VAL);
  // R2
  wr_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn |=> regQ == ($past(busWrData) & RSV_MASK));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |=> $stable(regQ));
  // R2
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRdData[4] == 1'b0);
endmodule

// File: rtl/rs_line_mux.sv
module rs_line_mux
  import rs_router_pkg::*;
#(
  parameter int N_UART = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  rsCtl_t            ctl,
  input  logic [N_UART-1:0] uartTx,
  output logic [N_UART-1:0] uartRx,
  output logic [N_UART-1:0] uartCts,
  input  logic              conRxd,
  input  logic              conCts,
  input  logic              conDsr,
  output logic              conTxd,
  output logic              conRts,
  output logic              conDtr,
  output logic              drvForceOn,
  output logic              drvForceOff
);
  logic bothEn, anyEn, priIdx, secIdx;
  logic [N_UART-1:0] enVec;

  assign enVec  = {ctl.en1, ctl.en0};
  assign bothEn = ctl.en0 & ctl.en1;
  assign anyEn  = ctl.en0 | ctl.en1;
  assign priIdx = bothEn ? ctl.pri1 : ctl.en1;
  assign secIdx = ~priIdx;

  assign conTxd      = anyEn ? uartTx[priIdx] : 1'b1;
  assign conDtr      = bothEn ? uartTx[secIdx] : ctl.dtrBit;
  assign conRts      = ctl.rtsBit;
  assign drvForceOff = ctl.forceOff;
  assign drvForceOn  = ctl.forceOn & ~ctl.forceOff;

  for (genvar i = 0; i < N_UART; i++) begin : g_uart
    logic isPri, isSec;
    assign isPri = enVec[i] && (priIdx == 1'(i));
    assign isSec = bothEn && (secIdx == 1'(i));
    assign uartRx[i]  = isPri ? conRxd : (isSec ? conDsr : 1'b1);
    assign uartCts[i] = isPri & conCts;

    // R8
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
      !enVec[i] |-> (uartRx[i] && !uartCts[i]));
  end

  // R3
  force_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({drvForceOn, drvForceOff}));
  // R7
  sec_rx_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.en0 && ctl.en1 && ctl.pri1) |-> (uartRx[0] == conDsr && !uartCts[0]));
  // R8
  idle_tx_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.en0 || ctl.en1) |-> conTxd);
endmodule

// File: rtl/rs_port_router.sv
module rs_port_router
  import rs_router_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWrEn,
  input  logic       busRdEn,
  input  logic [7:0] busWrData,
  output logic [7:0] busRdData,
  input  logic [1:0] uartTx,
  output logic [1:0] uartRx,
  output logic [1:0] uartCts,
  input  logic       conRxd,
  input  logic       conCts,
  input  logic       conDsr,
  output logic       conTxd,
  output logic       conRts,
  output logic       conDtr,
  output logic       drvForceOn,
  output logic       drvForceOff
);
  rsCtl_t ctl;

  rs_ctl_regs regs_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .busRdData(busRdData), .ctl(ctl)
  );

  rs_line_mux #(.N_UART(2)) mux_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .uartTx(uartTx), .uartRx(uartRx),
    .uartCts(uartCts), .conRxd(conRxd), .conCts(conCts), .conDsr(conDsr),
    .conTxd(conTxd), .conRts(conRts), .conDtr(conDtr),
    .drvForceOn(drvForceOn), .drvForceOff(drvForceOff)
  );
endmodule

// File: tb/rs_port_router_tb_top.sv
module rs_port_router_tb_top;
  logic clk = 0, rstN = 0, busWrEn = 0, busRdEn = 0;
  logic [7:0] busWrData = 0, busRdData;
  logic [1:0] uartTx = 2'b11, uartRx, uartCts;
  logic conRxd = 1, conCts = 0, conDsr = 1;
  logic conTxd, conRts, conDtr, drvForceOn, drvForceOff;
  int nRun = 0, nFail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rs_port_router dut_i (.*);

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(logic [7:0] v);
    @(negedge clk); busWrEn = 1; busWrData = v;
    @(negedge clk); busWrEn = 0;
  endtask

  // Expected pins: {conTxd, conDtr, conRts, drvForceOn, drvForceOff,
  //                 uartRx[1], uartRx[0], uartCts[1], uartCts[0]}
  function automatic logic [8:0] model(logic [7:0] r, logic [1:0] tx,
                                       logic rxd, logic cts, logic dsr);
    logic txd, dtr, rx1, rx0, c1, c0;
    rx1 = 1; rx0 = 1; c1 = 0; c0 = 0; txd = 1; dtr = r[2];
    case ({r[6], r[5]})
      2'b01: begin txd = tx[0]; rx0 = rxd; c0 = cts; end
      2'b10: begin txd = tx[1]; rx1 = rxd; c1 = cts; end
      2'b11: if (r[7]) begin
               txd = tx[1]; rx1 = rxd; c1 = cts; dtr = tx[0]; rx0 = dsr;
             end else begin
               txd = tx[0]; rx0 = rxd; c0 = cts; dtr = tx[1]; rx1 = dsr;
             end
      default: ;
    endcase
    return {txd, dtr, r[3], r[0] && !r[1], r[1], rx1, rx0, c1, c0};
  endfunction

  function automatic string reqOf(logic [7:0] r);
    if (r[6] && r[5]) return "R7";
    if (r[6] || r[5]) return "R6";
    return "R8";
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    busRdEn = 1; #1;
    check("R1 reset value", 16'(busRdData), 16'h20);
    uartTx = 2'b10; #1;
    check("R1 uart0 tx routed", 16'(conTxd), 16'd0);
    conRxd = 0; #1;
    check("R1 uart0 rx routed", 16'(uartRx), 16'b10);
    conRxd = 1;
    busRdEn = 0; #1;
    check("R2 read strobe low", 16'(busRdData), 16'h00);

    for (int v = 0; v < 256; v++) begin
      logic [7:0] r;
      wrReg(8'(v));
      r = 8'(v) & 8'hEF;
      busRdEn = 1; #1;
      check("R2 readback", 16'(busRdData), 16'(r));
      check("R3 driver force", 16'({drvForceOn, drvForceOff}),
            16'({r[0] && !r[1], r[1]}));
      check("R4 rts", 16'(conRts), 16'(r[3]));
      if (!(r[5] && r[6])) check("R5 dtr", 16'(conDtr), 16'(r[2]));
      for (int p = 0; p < 32; p++) begin
        logic [8:0] exp, act;
        {uartTx, conRxd, conCts, conDsr} = 5'(p);
        #1;
        act = {conTxd, conDtr, conRts, drvForceOn, drvForceOff,
               uartRx, uartCts};
        exp = model(r, uartTx, conRxd, conCts, conDsr);
        check(reqOf(r), 16'(act), 16'(exp));
      end
    end

    // R2 hold: no write strobe, data changes, register keeps its value
    wrReg(8'h6C);
    busWrData = 8'h00;
    repeat (3) @(negedge clk);
    #1;
    check("R2 hold", 16'(busRdData), 16'h6C);
    // R5 both enabled, bit 2 flipped: dtr follows the secondary tx only
    uartTx = 2'b01;
    wrReg(8'h64); #1;
    check("R5 dtr bit ignored", 16'(conDtr), 16'd0);
    wrReg(8'h60); #1;
    check("R5 dtr bit ignored", 16'(conDtr), 16'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule